// File: doc/BRIEF.md
# Debug-Port Memory Read Engine

This block is a bus master that sits on the debug side of a chip. An external tool drives it through a small indexed register file with three registers: an address register, a control/status register and a data register. The tool writes an address, then writes the control register with its start bit set. The engine then arbitrates for a simple request/grant/ready system bus and fetches the data.

A single read of 8, 16 or 32 bits fetches one aligned double-word. The engine picks the byte lane from the low address bits. It places the value right-justified, with bytes swapped to little-endian order, in the data register. A 64-bit read, with or without burst, stores whole double-words in a 32-byte buffer. A burst stores up to four double-words. The tool then drains the buffer through the data register one 32-bit word per read, and each word is byte-swapped.

Completion is shown by a data-valid status bit and a ready output, so the tool can wait on the pin instead of polling. A bus error sets an error bit instead.

Top module: `dbg_mem_engine`

## Requirements
- R1: Register index 0x7 selects control/status, index 0x9 selects the address register and index 0xA selects the data register. The address register reads back the last value written to it.
- R2: The control layout is: bit 31 start (always reads 0), bits [30:28] map select, [27:26] priority, [25] direction (0 = read), [24:22] size, [21:8] count, [7] burst enable, [1] error status, [0] data-valid status. Bits [6:0] cannot be written, and bits [1:0] change only through accesses. After reset every control bit reads 0, and the ready output and bus request are low.
- R3: Size codes 0, 1 and 2 make a single 8-, 16- or 32-bit read. The byte lane is chosen by address bits [2:0], [2:1] or [2]. Memory is big-endian, and the result is right-justified and byte-swapped. With bytes DE AD BE EF 01 23 45 67 at 0x40..0x47: 8-bit at 0x40 gives 0x000000DE, at 0x43 gives 0x000000EF and at 0x45 gives 0x00000023. 16-bit at 0x40 gives 0x0000ADDE and at 0x42 gives 0x0000EFBE. 32-bit at 0x40 gives 0xEFBEADDE and at 0x44 gives 0x67452301.
- R4: Every bus address is aligned to 8 bytes, and address bits [2:0] are dropped. Successive beats of a burst step the address by 8. Size code 3 with burst enabled makes count beats (1 to 4). A count of 0 or 1, a non-burst request, or a size other than 3 makes exactly one beat.
- R5: An access that finishes without error sets data-valid to 1 and error to 0, and raises the ready output. Ready stays high until the next start, and ready always equals data-valid.
- R6: After a size-3 access, successive data-register reads return the stored words in address order, starting at the first double-word. Each word is built from bytes a, a+1, a+2, a+3 as {a+3, a+2, a+1, a}.
- R7: A bus error response ends the access. It sets the error bit, leaves data-valid at 0 and keeps the ready output low.
- R8: Starting an access clears data-valid, error and ready, and resets the readout pointer to the first word.
- R9: While an access is in progress, a data-register read returns the contents the data register showed before the start, and the read does not advance the readout pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (data-register side effects) |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| xfer_ready | output | 1 | Access completed without error |
| bus_req | output | 1 | System bus request, held for the whole access |
| bus_addr | output | ADDR_W | Double-word-aligned bus address |
| bus_gnt | input | 1 | System bus grant |
| bus_rdy | input | 1 | One beat of read data is valid |
| bus_err | input | 1 | Error response for the current beat |
| bus_rdata | input | 64 | Read data, lowest-address byte in bits [63:56] |

## Verification
Single reads are tried at every size and at several offsets within one double-word. Reads at the same address but different sizes separate the lane-select errors from the byte-swap errors, and counts of 0 and 1 are both used. Bursts start from a misaligned address, and a 64-bit non-burst read fetches two words, which separates the address masking from the beat count. A restart after a partial readout, with reads issued while the access is still running, separates the held data and pointer from the fresh buffer. An address in the error region is followed by a good access, which shows that the error bit and ready are cleared.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;

  localparam logic [3:0] IDX_CTRL = 4'h7;
  localparam logic [3:0] IDX_ADDR = 4'h9;
  localparam logic [3:0] IDX_DATA = 4'hA;
  localparam int         CNT_W    = 14;
  localparam logic [2:0] SZ_DWORD = 3'b011;

  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_XFER} seq_state_t;

  typedef struct packed {
    logic [2:0]       map_sel;
    logic [1:0]       prio;
    logic             wr_dir;
    logic [2:0]       size;
    logic [CNT_W-1:0] count;
    logic             burst_en;
  } ctrl_t;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Select the addressed lane of a big-endian double-word and right-justify it
  function automatic logic [31:0] pick_lane(input logic [63:0] dw,
                                            input logic [2:0]  off,
                                            input logic [1:0]  size);
    logic [2:0]  base;
    logic [63:0] sh;
    logic [31:0] sw;
    case (size)
      2'd0:    base = off;
      2'd1:    base = {off[2:1], 1'b0};
      default: base = {off[2], 2'b00};
    endcase
    sh = dw << {base, 3'b000};
    sw = swap32(sh[63:32]);
    case (size)
      2'd0:    return {24'h0, sw[7:0]};
      2'd1:    return {16'h0, sw[15:0]};
      default: return sw;
    endcase
  endfunction

  function automatic int unsigned beat_total(input logic [2:0]       size,
                                             input logic [CNT_W-1:0] count,
                                             input logic             burst_en,
                                             input int unsigned      max_beats);
    int unsigned n;
    n = 32'(count);
    if (size != SZ_DWORD || !burst_en || n <= 1) return 1;
    if (n > max_beats) return max_beats;
    return n;
  endfunction

endpackage

// File: rtl/dbg_lane_align.sv
module dbg_lane_align
  import dbg_mem_pkg::*;
(
  input  logic [63:0] dword,
  input  logic [2:0]  offset,
  input  logic [1:0]  size,
  output logic [31:0] word
);
  assign word = pick_lane(dword, offset, size);
endmodule

// File: rtl/dbg_burst_buf.sv
module dbg_burst_buf
  import dbg_mem_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  localparam int WORDS    = 2 * MAX_BEATS,
  localparam int PTR_W    = $clog2(WORDS),
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BEAT_W-1:0] wr_beat,
  input  logic [63:0]       wr_dword,
  input  logic              clr,
  input  logic              adv,
  output logic [31:0]       rd_word,
  output logic [PTR_W-1:0]  rd_ptr
);
  logic [31:0] words_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[w] <= '0;
      end else if (wr_en && wr_beat == BEAT_W'(w / 2)) begin
        words_q[w] <= swap32((w % 2 == 0) ? wr_dword[63:32] : wr_dword[31:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
    end else if (adv) begin
      rd_ptr <= (rd_ptr == PTR_W'(WORDS - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  end

  assign rd_word = words_q[rd_ptr];
endmodule

// File: rtl/dbg_bus_seq.sv
module dbg_bus_seq
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BEAT_W-1:0] start_beats,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  input  logic              bus_err,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              busy,
  output logic              beat_evt,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              done_ok,
  output logic              fail
);
  seq_state_t        state_q;
  logic [BEAT_W-1:0] last_q;

  assign busy     = (state_q != ST_IDLE);
  assign bus_req  = busy;
  assign beat_evt = (state_q == ST_XFER) && bus_rdy && !bus_err;
  assign fail     = (state_q == ST_XFER) && bus_err;
  assign done_ok  = beat_evt && (beat_idx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bus_addr <= '0;
      beat_idx <= '0;
      last_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          bus_addr <= {start_addr[ADDR_W-1:3], 3'b000};
          last_q   <= start_beats - BEAT_W'(1);
          beat_idx <= '0;
          state_q  <= ST_ARB;
        end
        ST_ARB: if (bus_gnt) state_q <= ST_XFER;
        default: begin
          if (fail || done_ok) begin
            state_q <= ST_IDLE;
          end else if (beat_evt) begin
            beat_idx <= beat_idx + BEAT_W'(1);
            bus_addr <= bus_addr + ADDR_W'(8);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_mem_engine.sv
module dbg_mem_engine
  import dbg_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 4,
  localparam int WORDS    = 2 * MAX_BEATS,
  localparam int PTR_W    = $clog2(WORDS),
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [3:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              xfer_ready,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  input  logic              bus_err,
  input  logic [63:0]       bus_rdata
);
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_new;
  logic [ADDR_W-1:0] addr_q;
  logic              dv_q, err_q, rdy_q, buffered_q;
  logic [31:0]       hold_q, single_q;
  logic [2:0]        off_q;
  logic [1:0]        size_q;

  // named internal events
  logic              busy, start_evt, beat_evt, done_ok_evt, fail_evt;
  logic              wr_ctrl, wr_addr, data_rd_evt, adv_evt;
  logic [BEAT_W-1:0] beat_idx, beats_start;
  logic [31:0]       lane_word, buf_word, data_view;
  logic [PTR_W-1:0]  rd_ptr;

  assign ctrl_new    = ctrl_t'(reg_wdata[30:7]);
  assign wr_ctrl     = reg_wr_en && reg_idx == IDX_CTRL && !busy;
  assign wr_addr     = reg_wr_en && reg_idx == IDX_ADDR && !busy;
  assign start_evt   = wr_ctrl && reg_wdata[31];
  assign data_rd_evt = reg_rd_en && reg_idx == IDX_DATA;
  assign adv_evt     = data_rd_evt && !busy && buffered_q;
  assign beats_start = BEAT_W'(beat_total(ctrl_new.size, ctrl_new.count,
                                          ctrl_new.burst_en, MAX_BEATS));

  dbg_bus_seq #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start_evt), .start_addr(addr_q), .start_beats(beats_start),
    .bus_gnt(bus_gnt), .bus_rdy(bus_rdy), .bus_err(bus_err),
    .bus_req(bus_req), .bus_addr(bus_addr), .busy(busy),
    .beat_evt(beat_evt), .beat_idx(beat_idx),
    .done_ok(done_ok_evt), .fail(fail_evt)
  );

  dbg_burst_buf #(.MAX_BEATS(MAX_BEATS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(beat_evt && buffered_q), .wr_beat(beat_idx), .wr_dword(bus_rdata),
    .clr(start_evt), .adv(adv_evt),
    .rd_word(buf_word), .rd_ptr(rd_ptr)
  );

  dbg_lane_align u_align (
    .dword(bus_rdata), .offset(off_q), .size(size_q), .word(lane_word)
  );

  assign data_view  = busy ? hold_q : (buffered_q ? buf_word : single_q);
  assign xfer_ready = rdy_q;

  always_comb begin
    case (reg_idx)
      IDX_CTRL: reg_rdata = {1'b0, ctrl_q, 5'b0, err_q, dv_q};
      IDX_ADDR: reg_rdata = 32'(addr_q);
      IDX_DATA: reg_rdata = data_view;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      addr_q     <= '0;
      dv_q       <= 1'b0;
      err_q      <= 1'b0;
      rdy_q      <= 1'b0;
      buffered_q <= 1'b0;
      hold_q     <= '0;
      single_q   <= '0;
      off_q      <= '0;
      size_q     <= '0;
    end else begin
      if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (start_evt) begin
        dv_q       <= 1'b0;
        err_q      <= 1'b0;
        rdy_q      <= 1'b0;
        hold_q     <= data_view;
        buffered_q <= (ctrl_new.size == SZ_DWORD);
        off_q      <= addr_q[2:0];
        size_q     <= ctrl_new.size[1:0];
      end
      if (beat_evt && !buffered_q) single_q <= lane_word;
      if (done_ok_evt) begin
        dv_q  <= 1'b1;
        rdy_q <= 1'b1;
      end
      if (fail_evt) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_mem_engine_chk.sv
module dbg_mem_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              dv,
  input logic              err,
  input logic              busy,
  input logic              start_evt,
  input logic              beat_evt,
  input logic              done_ok_evt,
  input logic              fail_evt,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       data_view,
  input logic [PTR_W-1:0]  rd_ptr
);
  p_ready_tracks_dv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready == dv);

  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok_evt |=> ready && dv && !err);

  p_error_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> err && !dv && !ready);

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !ready && !dv && !err && rd_ptr == '0);

  p_aligned_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |-> bus_addr[2:0] == 3'b000);

  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_evt && !done_ok_evt |=> bus_addr == $past(bus_addr) + ADDR_W'(8));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_ok_evt && !fail_evt |=> $stable(data_view) && $stable(rd_ptr));
endmodule

bind dbg_mem_engine dbg_mem_engine_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(xfer_ready), .dv(dv_q), .err(err_q),
  .busy(busy), .start_evt(start_evt), .beat_evt(beat_evt),
  .done_ok_evt(done_ok_evt), .fail_evt(fail_evt), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .bus_addr(bus_addr), .data_view(data_view), .rd_ptr(rd_ptr)
);

// File: tb/tb_dbg_mem_engine.sv
`timescale 1ns/1ps
module tb_dbg_mem_engine;
  import dbg_mem_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_ready, bus_req;
  logic [31:0] bus_addr;
  logic        bus_gnt = 1'b0, bus_rdy = 1'b0, bus_err = 1'b0;
  logic [63:0] bus_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];

  // reference model state
  bit          exp_ready = 1'b0, pending_start = 1'b0;
  int          exp_beats = 0, beats_done = 0, lat_cnt = 0;
  logic [31:0] exp_next_addr = '0;

  always #4 clk = ~clk;

  dbg_mem_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_ready(xfer_ready), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_rdy(bus_rdy), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mword(input int a);
    return {mem[(a+3)%256], mem[(a+2)%256], mem[(a+1)%256], mem[a%256]};
  endfunction

  function automatic logic [63:0] mdword(input logic [31:0] a);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[63-8*i -: 8] = mem[(int'(a[7:0]) & 8'hF8) + i];
    return d;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit st, input logic [2:0] sz,
                                          input logic [13:0] cnt, input bit bst);
    return {st, 3'd0, 2'd0, 1'b0, sz, cnt, bst, 7'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); #1;
    reg_idx = idx; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); #1;
    reg_idx = idx; reg_rd_en = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
  endtask

  task automatic start_acc(input logic [31:0] a, input logic [2:0] sz,
                           input logic [13:0] cnt, input bit bst, input int nb);
    write_reg(IDX_ADDR, a);
    exp_beats = nb;
    exp_next_addr = {a[31:3], 3'b000};
    write_reg(IDX_CTRL, mk_ctrl(1'b1, sz, cnt, bst));
    pending_start = 1'b1;
  endtask

  task automatic wait_done();
    while (bus_req) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic single(input logic [31:0] a, input logic [2:0] sz,
                        input logic [13:0] cnt, input logic [31:0] exp);
    logic [31:0] d;
    start_acc(a, sz, cnt, 1'b0, 1);
    wait_done();
    read_reg(IDX_DATA, d);
    check($sformatf("R3 size%0d addr 0x%0h", sz, a), d, exp);
    read_reg(IDX_CTRL, d);
    check("R5 status after single", {30'd0, d[1:0]}, 32'h1);
  endtask

  // bus memory model, per-clock ready comparison
  initial begin
    forever begin
      @(negedge clk);
      if (pending_start) begin
        exp_ready = 1'b0; beats_done = 0; pending_start = 1'b0;
      end
      if (bus_rdy) begin
        beats_done++;
        if (beats_done == exp_beats) exp_ready = 1'b1;
      end
      if (rst_n) begin
        checks++;
        if (xfer_ready !== exp_ready) begin
          errors++;
          $display("FAIL R5/R7/R8 ready: actual %0b expected %0b", xfer_ready, exp_ready);
        end
      end
      if (!bus_req) begin
        bus_gnt = 0; bus_rdy = 0; bus_err = 0; lat_cnt = 0;
      end else if (!bus_gnt) begin
        bus_gnt = 1; lat_cnt = 0;
      end else if (bus_rdy || bus_err) begin
        bus_rdy = 0; bus_err = 0; lat_cnt = 0;
      end else if (lat_cnt < 2) begin
        lat_cnt++;
      end else begin
        check("R4 beat address", bus_addr, exp_next_addr);
        exp_next_addr += 32'd8;
        if (bus_addr[31:28] == 4'hE) bus_err = 1;
        else begin bus_rdy = 1; bus_rdata = mdword(bus_addr); end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, wv;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) % 256);
    mem[8'h40] = 8'hDE; mem[8'h41] = 8'hAD; mem[8'h42] = 8'hBE; mem[8'h43] = 8'hEF;
    mem[8'h44] = 8'h01; mem[8'h45] = 8'h23; mem[8'h46] = 8'h45; mem[8'h47] = 8'h67;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state R2
    read_reg(IDX_CTRL, d);
    check("R2 control after reset", d, 32'h0);
    check("R2 ready/request after reset", {30'd0, xfer_ready, bus_req}, 32'h0);

    // register map R1 / R2
    write_reg(IDX_ADDR, 32'h1234_5678);
    read_reg(IDX_ADDR, d);
    check("R1 address readback", d, 32'h1234_5678);
    wv = {1'b0, 3'd5, 2'd2, 1'b1, 3'd2, 14'h2AB, 1'b1, 7'h7F};
    write_reg(IDX_CTRL, wv);
    read_reg(IDX_CTRL, d);
    check("R2 control fields readback", d, wv & ~32'h7F);
    check("R1 no start without bit 31", {31'd0, bus_req}, 32'h0);
    write_reg(IDX_CTRL, mk_ctrl(1'b1, 3'd2, 14'd0, 1'b0) | 32'h0000_0003);
    exp_beats = 1; exp_next_addr = 32'h1234_5678;
    pending_start = 1'b1;
    read_reg(IDX_CTRL, d);
    check("R2 start bit reads 0", {31'd0, d[31]}, 32'h0);
    wait_done();

    // single reads R3, count 0 and 1 R4
    single(32'h40, 3'd0, 14'd0, 32'h0000_00DE);
    single(32'h43, 3'd0, 14'd1, 32'h0000_00EF);
    single(32'h45, 3'd0, 14'd0, 32'h0000_0023);
    single(32'h40, 3'd1, 14'd1, 32'h0000_ADDE);
    single(32'h42, 3'd1, 14'd0, 32'h0000_EFBE);
    single(32'h40, 3'd2, 14'd0, 32'hEFBE_ADDE);
    single(32'h44, 3'd2, 14'd1, 32'h6745_2301);

    // burst from misaligned address R4 R6
    start_acc(32'h83, SZ_DWORD, 14'd4, 1'b1, 4);
    wait_done();
    for (int k = 0; k < 8; k++) begin
      read_reg(IDX_DATA, d);
      check($sformatf("R6 burst word %0d", k), d, mword(8'h80 + 4 * k));
    end

    // partial readout then restart R8 R9
    start_acc(32'h40, SZ_DWORD, 14'd2, 1'b1, 2);
    wait_done();
    read_reg(IDX_DATA, d);
    check("R6 two-beat word 0", d, 32'hEFBE_ADDE);
    read_reg(IDX_DATA, d);
    check("R6 two-beat word 1", d, 32'h6745_2301);
    start_acc(32'hA0, SZ_DWORD, 14'd4, 1'b1, 4);
    read_reg(IDX_DATA, d);
    check("R9 busy read holds", d, mword(8'h48));
    read_reg(IDX_DATA, d);
    check("R9 busy read does not advance", d, mword(8'h48));
    read_reg(IDX_CTRL, d);
    check("R8 status cleared at start", {30'd0, d[1:0]}, 32'h0);
    wait_done();
    for (int k = 0; k < 8; k++) begin
      read_reg(IDX_DATA, d);
      check($sformatf("R8 pointer reset, word %0d", k), d, mword(8'hA0 + 4 * k));
    end

    // bus error R7
    start_acc(32'hE000_0040, 3'd2, 14'd0, 1'b0, 1);
    wait_done();
    read_reg(IDX_CTRL, d);
    check("R7 error status", {30'd0, d[1:0]}, 32'h2);
    check("R7 ready low", {31'd0, xfer_ready}, 32'h0);

    // recovery after error R8
    start_acc(32'h40, 3'd2, 14'd0, 1'b0, 1);
    read_reg(IDX_CTRL, d);
    check("R8 error cleared at start", {30'd0, d[1:0]}, 32'h0);
    wait_done();
    read_reg(IDX_DATA, d);
    check("R3 read after error", d, 32'hEFBE_ADDE);

    // 64-bit non-burst: one beat, two words R4 R6
    start_acc(32'h44, SZ_DWORD, 14'd4, 1'b0, 1);
    wait_done();
    read_reg(IDX_DATA, d);
    check("R6 dword word 0", d, 32'hEFBE_ADDE);
    read_reg(IDX_DATA, d);
    check("R6 dword word 1", d, 32'h6745_2301);
    read_reg(IDX_CTRL, d);
    check("R5 status after dword", {30'd0, d[1:0]}, 32'h1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule